// File: doc/BRIEF.md
# Serial-Bus Byte EEPROM Slave Model

This block is a synthesizable model of a nonvolatile byte memory that answers as a slave on a four-wire serial peripheral bus. The host selects it with an active-low chip select, shifts an 8-bit command and, where needed, a 16-bit address into it, and then either reads bytes out sequentially or writes up to one page of bytes into a 16-byte page latch. The array itself is a register file of `MEM_BYTES` bytes (2048 by default, 1024 for the smaller variant). All serial inputs are oversampled by the system clock `clk`, so `clk` must run at least four times faster than the serial clock.

A write is not applied while bytes are arriving. It is held in the page latch and committed only when chip select rises after a whole number of data bytes. The commit starts a self-timed write cycle of `WC_CYCLES` clocks. During that cycle the block reports busy and accepts nothing but the status read. A write-enable latch gates every write. A two-bit block-protect field in the status register fences off the top quarter, the top half or the whole array, and that field can only change while the write-protect pin is high. An active-low hold pin pauses a transfer without ending it.

Top module: `spi_eeprom_slave`

## Requirements
- R1: Only serial clock modes 0 and 3 are supported: `mosi` is sampled on the rising `sck` edge and `miso` changes after the falling edge, most significant bit first in both directions; with `sck` idling high at select, the first falling edge has no effect.
- R2: Command codes are 0x06 set write-enable, 0x04 clear write-enable, 0x05 read status, 0x01 write status, 0x03 read and 0x02 write. Any other code makes the block ignore the rest of the transfer.
- R3: A read takes a 16-bit address, most significant byte first, and ignores the address bits above the array width. The byte at that address is shifted out next, and each further 8 clocks return the following byte, wrapping from the last address to 0.
- R4: Data bytes of a write fill the page latch starting at the address offset inside its 16-byte page; offsets wrap from 15 to 0 in the same page.
- R5: A write or status write is committed only on the rising edge of `cs_n`, and only if at least one data byte arrived, no partial byte is pending, and the write-enable latch is set; otherwise nothing changes and no write cycle starts.
- R6: A committed write starts a write cycle of `WC_CYCLES` clocks. During it only read status is accepted: any other command produces no output (`miso_oe` stays 0) and has no effect.
- R7: Status byte: bit 0 busy, bit 1 write-enable latch, bits 3:2 block protect, bits 7:4 and bits 7:4 zero; it is refreshed for every byte while the status command continues.
- R8: The write-enable latch is set by 0x06 and cleared by 0x04, by reset and at the end of every write cycle; writes while it is clear are discarded.
- R9: Block protect 0 protects nothing, 1 the top quarter, 2 the top half, 3 the whole array; bytes addressed into a protected range are dropped, while the write cycle still runs.
- R10: While `wp_n` is low, status writes are refused (no change, no write cycle, write-enable kept); array writes are unaffected by `wp_n`.
- R11: While `hold_n` is low, `sck` and `mosi` transitions are ignored, `miso_oe` is 0 and all transfer state is frozen; the transfer continues unchanged once `hold_n` returns high.
- R12: While `cs_n` is high, `sck` and `mosi` are ignored and `miso_oe` is 0; a `cs_n` rise while `hold_n` is low aborts the transfer without committing anything.
- R13: After reset the status byte reads 0x00 and `miso_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data into the slave |
| hold_n | input | 1 | Active-low pause of the current transfer |
| wp_n | input | 1 | Active-low guard for status writes |
| miso | output | 1 | Serial data out of the slave |
| miso_oe | output | 1 | Output enable for `miso` (0 means high impedance) |

## Verification
A wrong address or page offset lands a byte in the wrong cell. It shows up only when that cell is read back, so the bench fills the whole array and then reads all of it in one sequential sweep that crosses the wrap point. A wrong write-enable, busy or protect state shows up at once in the next status byte, or one write cycle later as a cell that changed when it should not have. Hold and abort mistakes corrupt the very next bit shifted out, or leave `miso_oe` high during a pause.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;
    localparam logic [7:0] CMD_WEL_SET = 8'h06;
    localparam logic [7:0] CMD_WEL_CLR = 8'h04;
    localparam logic [7:0] CMD_STAT_RD = 8'h05;
    localparam logic [7:0] CMD_STAT_WR = 8'h01;
    localparam logic [7:0] CMD_MEM_RD  = 8'h03;
    localparam logic [7:0] CMD_MEM_WR  = 8'h02;

    localparam int PAGE_AW    = 4;
    localparam int PAGE_BYTES = 1 << PAGE_AW;

    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_RDATA,
        PH_WDATA,
        PH_STOUT,
        PH_STIN,
        PH_SKIP
    } phase_e;
endpackage

// File: rtl/eep_wtimer.sv
module eep_wtimer #(
    parameter int CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (q.busy) begin
            if (q.cnt == CW'(CYCLES - 1)) begin
                d.busy = 1'b0;
                d.cnt  = '0;
                done   = 1'b1;
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end else if (start) begin
            d.busy = 1'b1;
            d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
endmodule

// File: rtl/eep_blockprot.sv
module eep_blockprot (
    input  logic [1:0] bp,
    input  logic [1:0] quarter,
    output logic       prot
);
    always_comb begin
        unique case (bp)
            2'd0:    prot = 1'b0;
            2'd1:    prot = (quarter == 2'd3);
            2'd2:    prot = quarter[1];
            default: prot = 1'b1;
        endcase
    end
endmodule

// File: rtl/eep_store.sv
module eep_store
    import spi_eeprom_pkg::*;
#(
    parameter int MEM_BYTES = 2048,
    localparam int AW  = $clog2(MEM_BYTES),
    localparam int PGW = AW - PAGE_AW
) (
    input  logic                            clk,
    input  logic [PGW-1:0]                  wr_page,
    input  logic [PAGE_BYTES-1:0][7:0]      wr_data,
    input  logic [PAGE_BYTES-1:0]           wr_mask,
    input  logic [AW-1:0]                   rd_addr,
    output logic [7:0]                      rd_data
);
    logic [7:0] mem [MEM_BYTES];

    always_ff @(posedge clk) begin
        for (int i = 0; i < PAGE_BYTES; i++) begin
            if (wr_mask[i]) mem[{wr_page, PAGE_AW'(i)}] <= wr_data[i];
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
    import spi_eeprom_pkg::*;
#(
    parameter int MEM_BYTES = 2048,
    parameter int WC_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    input  logic hold_n,
    input  logic wp_n,
    output logic miso,
    output logic miso_oe
);
    localparam int AW  = $clog2(MEM_BYTES);
    localparam int PGW = AW - PAGE_AW;
    localparam int HW  = AW - 8;

    typedef struct packed {
        phase_e                       ph;
        logic [2:0]                   bitn;
        logic [6:0]                   sin;
        logic [7:0]                   sout;
        logic                         so;
        logic                         so_en;
        logic                         abyte;
        logic [HW-1:0]                ahi;
        logic [AW-1:0]                addr;
        logic                         is_wr;
        logic [PAGE_BYTES-1:0][7:0]   lat;
        logic [PAGE_BYTES-1:0]        lmask;
        logic [PAGE_AW-1:0]           loff;
        logic                         got;
        logic [1:0]                   st_bp;
        logic                         wel;
        logic [1:0]                   bp;
        logic                         sck_q;
        logic                         cs_q;
    } st_t;

    st_t q, d;

    logic                  busy_w, done_w, tstart, prot_w, wr_any;
    logic                  wel_w;
    logic [1:0]            bp_w;
    logic [PAGE_BYTES-1:0] wr_mask;
    logic [AW-1:0]         rd_addr;
    logic [7:0]            rd_data;
    logic [7:0]            byte_in;
    logic [AW-1:0]         a_full;
    logic [7:0]            status_now;
    logic                  sck_rise, sck_fall, cs_up, byte_end;

    eep_wtimer #(.CYCLES(WC_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tstart),
        .busy  (busy_w),
        .done  (done_w)
    );

    eep_blockprot u_prot (
        .bp      (q.bp),
        .quarter (q.addr[AW-1 -: 2]),
        .prot    (prot_w)
    );

    eep_store #(.MEM_BYTES(MEM_BYTES)) u_store (
        .clk     (clk),
        .wr_page (q.addr[AW-1:PAGE_AW]),
        .wr_data (q.lat),
        .wr_mask (wr_mask),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // edge detection and address mux, kept apart from the next-state logic
    always_comb begin
        sck_rise   = !cs_n && hold_n && sck && !q.sck_q;
        sck_fall   = !cs_n && hold_n && !sck && q.sck_q;
        cs_up      = cs_n && !q.cs_q;
        byte_in    = {q.sin, mosi};
        byte_end   = sck_rise && (q.bitn == 3'd7);
        a_full     = {q.ahi, byte_in};
        rd_addr    = (q.ph == PH_ADDR) ? a_full : q.addr;
        status_now = {4'b0000, q.bp, q.wel, busy_w};
    end

    always_comb begin
        d       = q;
        d.sck_q = sck;
        d.cs_q  = cs_n;
        wr_mask = '0;
        tstart  = 1'b0;

        if (cs_n) begin
            if (cs_up && hold_n && (q.bitn == 3'd0) && q.got && q.wel && !busy_w) begin
                if (q.ph == PH_WDATA) begin
                    wr_mask = q.lmask & {PAGE_BYTES{!prot_w}};
                    tstart  = 1'b1;
                end else if (q.ph == PH_STIN && wp_n) begin
                    d.bp   = q.st_bp;
                    tstart = 1'b1;
                end
            end
            d.ph    = PH_OPCODE;
            d.bitn  = '0;
            d.so    = 1'b0;
            d.so_en = 1'b0;
            d.got   = 1'b0;
        end else begin
            if (sck_fall && (q.ph == PH_RDATA || q.ph == PH_STOUT)) begin
                d.so    = q.sout[7];
                d.sout  = {q.sout[6:0], 1'b0};
                d.so_en = 1'b1;
            end
            if (sck_rise) begin
                d.sin  = byte_in[6:0];
                d.bitn = q.bitn + 3'd1;
            end
            if (byte_end) begin
                unique case (q.ph)
                    PH_OPCODE: begin
                        if (busy_w && byte_in != CMD_STAT_RD) begin
                            d.ph = PH_SKIP;
                        end else begin
                            unique case (byte_in)
                                CMD_WEL_SET: begin d.wel = 1'b1; d.ph = PH_SKIP; end
                                CMD_WEL_CLR: begin d.wel = 1'b0; d.ph = PH_SKIP; end
                                CMD_STAT_RD: begin d.ph = PH_STOUT; d.sout = status_now; end
                                CMD_STAT_WR: begin d.ph = PH_STIN; d.got = 1'b0; end
                                CMD_MEM_RD:  begin d.ph = PH_ADDR; d.abyte = 1'b0; d.is_wr = 1'b0; end
                                CMD_MEM_WR:  begin d.ph = PH_ADDR; d.abyte = 1'b0; d.is_wr = 1'b1; end
                                default:     d.ph = PH_SKIP;
                            endcase
                        end
                    end
                    PH_ADDR: begin
                        if (!q.abyte) begin
                            d.ahi   = byte_in[HW-1:0];
                            d.abyte = 1'b1;
                        end else if (q.is_wr) begin
                            d.addr  = a_full;
                            d.loff  = a_full[PAGE_AW-1:0];
                            d.lmask = '0;
                            d.got   = 1'b0;
                            d.ph    = PH_WDATA;
                        end else begin
                            d.sout = rd_data;
                            d.addr = a_full + AW'(1);
                            d.ph   = PH_RDATA;
                        end
                    end
                    PH_RDATA: begin
                        d.sout = rd_data;
                        d.addr = q.addr + AW'(1);
                    end
                    PH_STOUT: d.sout = status_now;
                    PH_WDATA: begin
                        d.lat[q.loff]   = byte_in;
                        d.lmask[q.loff] = 1'b1;
                        d.loff          = q.loff + PAGE_AW'(1);
                        d.got           = 1'b1;
                    end
                    PH_STIN: begin
                        d.st_bp = byte_in[3:2];
                        d.got   = 1'b1;
                    end
                    default: ;
                endcase
            end
        end

        if (done_w) d.wel = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.ph    <= PH_OPCODE;
            q.cs_q  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign miso    = q.so;
    assign miso_oe = q.so_en && !cs_n && hold_n;
    assign wel_w   = q.wel;
    assign bp_w    = q.bp;
    assign wr_any  = |wr_mask;
endmodule

// File: rtl/eep_sva.sv
module eep_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       hold_n,
    input logic       wp_n,
    input logic       miso_oe,
    input logic       busy,
    input logic       wel,
    input logic [1:0] bp,
    input logic       wr_any
);
    assert_deselect_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !miso_oe);

    assert_no_write_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_any);

    assert_write_then_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_any |=> busy);

    assert_busy_on_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cs_n) && $past(hold_n)));

    assert_wel_clear_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    assert_bp_guarded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bp) |-> $past(wp_n));
endmodule

bind spi_eeprom_slave eep_sva u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .hold_n  (hold_n),
    .wp_n    (wp_n),
    .miso_oe (miso_oe),
    .busy    (busy_w),
    .wel     (wel_w),
    .bp      (bp_w),
    .wr_any  (wr_any)
);

// File: tb/spi_eeprom_slave_tb.sv
module spi_eeprom_slave_tb;
    localparam int MB = 1024;
    localparam int WC = 64;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic hold_n = 1'b1, wp_n = 1'b1;
    logic miso, miso_oe;
    int   n_chk = 0, n_bad = 0;
    bit   m3 = 1'b0, finished = 1'b0, oe_seen = 1'b0;
    logic [7:0] mdl [MB];

    always #10 clk = ~clk;

    spi_eeprom_slave #(.MEM_BYTES(MB), .WC_CYCLES(WC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .hold_n(hold_n), .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'(((a * 37) + 11) ^ (a >> 5));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic r);
        sck = 1'b0; mosi = b; tick(2);
        r = miso;
        if (miso_oe) oe_seen = 1'b1;
        sck = 1'b1; tick(2);
    endtask

    task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) xbit(t[i], r[i]);
    endtask

    task automatic tx_begin();
        cs_n = 1'b0; oe_seen = 1'b0; tick(2);
    endtask

    task automatic tx_end();
        if (!m3) begin sck = 1'b0; tick(2); end
        cs_n = 1'b1; tick(3);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        tx_begin(); xbyte(op, r); tx_end();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] r;
        tx_begin(); xbyte(8'h05, r); xbyte(8'h00, s); tx_end();
    endtask

    task automatic wsr(input logic [7:0] v);
        logic [7:0] r;
        tx_begin(); xbyte(8'h01, r); xbyte(v, r); tx_end();
    endtask

    task automatic wr1(input int a, input logic [7:0] v);
        logic [7:0] r;
        tx_begin(); xbyte(8'h02, r); xbyte(8'(a >> 8), r); xbyte(8'(a), r);
        xbyte(v, r); tx_end();
    endtask

    task automatic rd1(input int a, output logic [7:0] v);
        logic [7:0] r;
        tx_begin(); xbyte(8'h03, r); xbyte(8'(a >> 8), r); xbyte(8'(a), r);
        xbyte(8'h00, v); tx_end();
    endtask

    task automatic wait_wc();
        tick(WC + 8);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] s, r, v;
        logic b;
        tick(3); rst_n = 1'b1; tick(3);

        // R13 reset state
        chk("R13 oe after reset", miso_oe, 0);
        rdsr(s); chk("R13 status after reset", s, 8'h00);

        // R4/R5/R6/R7 fill every page
        for (int p = 0; p < MB / 16; p++) begin
            cmd1(8'h06);
            tx_begin(); xbyte(8'h02, r); xbyte(8'(p * 16 >> 8), r); xbyte(8'(p * 16), r);
            for (int i = 0; i < 16; i++) begin
                mdl[p * 16 + i] = pat(p * 16 + i);
                xbyte(mdl[p * 16 + i], r);
            end
            tx_end();
            if (p == 0) begin
                rdsr(s); chk("R6 R7 status while busy", s, 8'h03);
            end
            wait_wc();
            if (p == 0) begin
                rdsr(s); chk("R8 wel cleared after cycle", s, 8'h00);
            end
        end

        // R3 sweep with garbage upper address bits and wrap
        tx_begin(); xbyte(8'h03, r); xbyte(8'hFC, r); xbyte(8'h00, r);
        for (int i = 0; i < MB + 2; i++) begin
            xbyte(8'h00, v);
            chk($sformatf("R3 R1 sweep byte %0d", i), v, mdl[i % MB]);
        end
        chk("R1 oe during read", oe_seen, 1);
        tx_end();

        // R8 write without enable is discarded
        wr1(5, 8'hA5); rdsr(s); chk("R8 no cycle without wel", s, 8'h00);
        rd1(5, v); chk("R8 data unchanged", v, mdl[5]);

        // R4 offsets wrap inside the page
        cmd1(8'h06);
        tx_begin(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h1E, r);
        for (int i = 0; i < 4; i++) begin
            v = 8'hC0 + 8'(i);
            mdl[16 + ((14 + i) % 16)] = v;
            xbyte(v, r);
        end
        tx_end(); wait_wc();
        for (int a = 16; a < 32; a++) begin
            rd1(a, v); chk($sformatf("R4 page wrap addr %0d", a), v, mdl[a]);
        end

        // R5 partial byte and missing data byte
        cmd1(8'h06);
        tx_begin(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h40, r);
        xbyte(8'h11, r); xbit(1'b1, b); xbit(1'b0, b); xbit(1'b1, b); tx_end();
        rdsr(s); chk("R5 partial byte no cycle", s, 8'h02);
        rd1(8'h40, v); chk("R5 partial byte no data", v, mdl[8'h40]);
        tx_begin(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h41, r); tx_end();
        rdsr(s); chk("R5 no data byte no cycle", s, 8'h02);

        // R8 clear command / R2 unknown opcode
        cmd1(8'h04); rdsr(s); chk("R8 clear command", s, 8'h00);
        cmd1(8'h06); cmd1(8'h7E); rdsr(s); chk("R2 unknown code ignored", s, 8'h02);

        // R6 busy blocks reads
        wr1(8'h50, 8'h3C); mdl[8'h50] = 8'h3C;
        tx_begin(); xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h50, r); xbyte(8'h00, v);
        chk("R6 no output while busy", oe_seen, 0);
        tx_end(); wait_wc();
        rd1(8'h50, v); chk("R6 write landed", v, 8'h3C);

        // R9 block protection per quarter
        for (int bpv = 1; bpv < 4; bpv++) begin
            cmd1(8'h06); wsr(8'(bpv << 2)); wait_wc();
            rdsr(s); chk($sformatf("R9 bp=%0d status", bpv), s, 8'(bpv << 2));
            for (int qd = 0; qd < 4; qd++) begin
                int a;
                bit pr;
                a = qd * 256 + 3 + bpv;
                v = ~mdl[a];
                cmd1(8'h06); wr1(a, v); wait_wc();
                pr = (bpv == 3) || (bpv == 2 && qd >= 2) || (bpv == 1 && qd == 3);
                if (!pr) mdl[a] = v;
                rd1(a, r); chk($sformatf("R9 bp=%0d quarter %0d", bpv, qd), r, mdl[a]);
            end
        end
        cmd1(8'h06); wsr(8'h00); wait_wc();

        // R10 write-protect pin
        wp_n = 1'b0;
        cmd1(8'h06); wsr(8'h0C); tick(4);
        rdsr(s); chk("R10 status write refused", s, 8'h02);
        wr1(16'h123, 8'h9D); mdl[16'h123] = 8'h9D; wait_wc();
        rd1(16'h123, v); chk("R10 array write allowed", v, 8'h9D);
        wp_n = 1'b1;

        // R11 hold during read
        tx_begin(); xbyte(8'h03, r); xbyte(8'h02, r); xbyte(8'h00, r);
        for (int i = 7; i >= 5; i--) xbit(1'b0, v[i]);
        hold_n = 1'b0; tick(2);
        for (int k = 0; k < 3; k++) begin
            sck = 1'b0; mosi = 1'b1; tick(2);
            chk("R11 oe low in hold", miso_oe, 0);
            sck = 1'b1; tick(2);
        end
        hold_n = 1'b1; tick(2);
        for (int i = 4; i >= 0; i--) xbit(1'b0, v[i]);
        chk("R11 read resumes", v, mdl[16'h200]);
        xbyte(8'h00, v); chk("R11 next byte", v, mdl[16'h201]);
        tx_end();

        // R11 hold during write
        cmd1(8'h06);
        tx_begin(); xbyte(8'h02, r); xbyte(8'h02, r); xbyte(8'h30, r);
        v = 8'h6B;
        for (int i = 7; i >= 4; i--) xbit(v[i], b);
        hold_n = 1'b0; tick(2);
        for (int k = 0; k < 3; k++) begin
            sck = 1'b0; mosi = k[0]; tick(2); sck = 1'b1; tick(2);
        end
        hold_n = 1'b1; tick(2);
        for (int i = 3; i >= 0; i--) xbit(v[i], b);
        tx_end(); mdl[16'h230] = v; wait_wc();
        rd1(16'h230, r); chk("R11 write through hold", r, 8'h6B);

        // R12 deselect during hold aborts
        cmd1(8'h06);
        tx_begin(); xbyte(8'h02, r); xbyte(8'h02, r); xbyte(8'h40, r); xbyte(8'hEE, r);
        sck = 1'b0; tick(2); hold_n = 1'b0; tick(2); cs_n = 1'b1; tick(2); hold_n = 1'b1; tick(2);
        rdsr(s); chk("R12 abort no cycle", s, 8'h02);
        rd1(16'h240, v); chk("R12 abort no data", v, mdl[16'h240]);

        // R12 deselected bus ignored
        cmd1(8'h04);
        for (int i = 7; i >= 0; i--) begin
            logic [7:0] en;
            en = 8'h06;
            xbit(en[i], b);
        end
        sck = 1'b0; tick(2);
        chk("R12 oe while deselected", oe_seen, 0);
        rdsr(s); chk("R12 ignored while deselected", s, 8'h00);

        // R1 mode 3 with R3 wrap
        m3 = 1'b1; sck = 1'b1; tick(2);
        tx_begin(); xbyte(8'h03, r); xbyte(8'h03, r); xbyte(8'hFE, r);
        for (int i = 0; i < 4; i++) begin
            xbyte(8'h00, v);
            chk($sformatf("R1 mode3 byte %0d", i), v, mdl[(16'h3FE + i) % MB]);
        end
        tx_end(); sck = 1'b0; m3 = 1'b0; tick(2);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule